// File: doc/BRIEF.md
# Parallel Channel Readout Lane Serializer

This block takes one readout cycle's worth of conversion results, 256 channels of 8-bit codes presented side by side, and streams them out over eight 8-bit lanes. Each lane owns a contiguous group of 32 channels and sends them one per clock, lowest channel first, so a whole frame leaves the block in 32 clocks. Only 250 of the channels are wired to real sources. The six spare channels at the top of the range are forced to zero on the lanes.

A producer offers a frame with a valid/ready handshake. The block copies the whole frame into an internal register on acceptance, so the producer may change its inputs straight away. A mode input sampled at the same moment selects normal data or a link-test pattern. The link-test pattern is a fixed, predictable code per lane and slot that lets the receiver check every lane without knowing the converted values.

While a frame is going out, every lane's valid is high and a start marker flags the first slot. The block accepts the next frame during the last slot of the current one, so frames can run back to back with no idle clock between them.

Top module: `frame_lane_serializer`

## Requirements
- R1: While reset is asserted and right after it, frameReady is 1, frameStart is 0, every bit of laneValid is 0 and laneData is all zeros.
- R2: A frame is accepted at a rising clock edge where frameValid and frameReady are both 1. frameReady is 0 during slots 0 to 30 of a frame in progress. It is 1 when no frame is in progress and during slot 31.
- R3: Starting in the cycle after acceptance, all eight laneValid bits stay high for exactly 32 consecutive cycles (slots 0 to 31). frameStart is high only in slot 0.
- R4: In normal mode, lane k (laneData bits 8k+7..8k) carries in slot s the channel c = 32k+s. Channel c is taken from frameData bits 8c+7..8c as they stood at acceptance.
- R5: In normal mode, channels 250 to 255 (lane 7, slots 26 to 31) are output as 8'h00, whatever their input value.
- R6: When testMode is 1 at acceptance, lane k in slot s outputs ((k<<5)|s) XOR 8'hA5 for every lane and slot, the spare channels included, in place of the converted data.
- R7: Changes to frameData or testMode after acceptance have no effect on the frame in progress.
- R8: A frame accepted during slot 31 starts its slot 0 in the very next cycle, with no idle cycle between the frames.
- R9: When a frame ends and no new frame was accepted, laneValid returns to 0, frameStart stays 0 and laneData is all zeros until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | Producer offers a frame |
| frameReady | output | 1 | Block can accept a frame at this edge |
| testMode | input | 1 | 1 selects the link-test pattern for the offered frame |
| frameData | input | 2048 | 256 channel codes, channel c at bits 8c+7..8c |
| laneData | output | 64 | Eight lane codes, lane k at bits 8k+7..8k |
| laneValid | output | 8 | One valid bit per lane |
| frameStart | output | 1 | High during slot 0 of each frame |

## Verification
Lane outputs come straight from the frame register and the slot counter, so slot 0 of a frame accepted at edge T is visible right after T and slot s right after edge T+s. frameReady depends only on the block's state, so it is valid before the edge it qualifies. The bench's reference model changes state on every rising edge from the inputs it drove half a cycle earlier. It compares every output on the falling edge, when both the model and the design have settled for the current slot. The back-to-back case is checked by holding a second offer through a frame and expecting its slot 0 on the cycle after slot 31.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;
  localparam int LANES    = 8;
  localparam int SLOTS    = 32;
  localparam int CODE_W   = 8;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int CHANNELS = LANES * SLOTS;
  localparam int CH_W     = $clog2(CHANNELS);

  typedef struct packed {
    logic              load;    // capture the offered frame at this edge
    logic              active;  // a frame is on the lanes
    logic [SLOT_W-1:0] slot;    // current slot inside the frame
  } seqStrobes_t;
endpackage

// File: rtl/lane_seq_ctrl.sv
module lane_seq_ctrl
  import lane_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameValid,
  output logic        frameReady,
  output logic        frameStart,
  output seqStrobes_t strobes
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic              lastSlot;
  logic              accept;

  assign lastSlot   = busy && (slot == LAST_SLOT);
  assign frameReady = !busy || lastSlot;
  assign accept     = frameValid && frameReady;
  assign frameStart = busy && (slot == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (lastSlot) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (busy) begin
      slot <= slot + 1'b1;
    end
  end

  assign strobes.load   = accept;
  assign strobes.active = busy;
  assign strobes.slot   = slot;

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastSlot) |=> (busy && slot == $past(slot) + 1'b1)); // R3
  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (frameStart && busy)); // R8
  AST_NO_RESTART_MID: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && busy && !lastSlot) |=> (slot != '0)); // R2
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (lastSlot && !frameValid) |=> !busy); // R9
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_ser_pkg::*;
#(
  parameter int unsigned        USED_CH     = 250,
  parameter logic [CODE_W-1:0]  PATTERN_KEY = 8'hA5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobes_t                  strobes,
  input  logic                         testModeIn,
  input  logic [CHANNELS*CODE_W-1:0]   frameData,
  output logic [LANES*CODE_W-1:0]      laneData,
  output logic [LANES-1:0]             laneValid
);
  localparam logic [CH_W:0] USED_LIM = (CH_W + 1)'(USED_CH);

  logic [CODE_W-1:0] frameReg [CHANNELS];
  logic              modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= 1'b0;
      for (int c = 0; c < CHANNELS; c++) frameReg[c] <= '0;
    end else if (strobes.load) begin
      modeReg <= testModeIn;
      for (int c = 0; c < CHANNELS; c++) frameReg[c] <= frameData[c*CODE_W +: CODE_W];
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [CH_W-1:0]   chIdx;
    logic [CODE_W-1:0] convCode;
    logic [CODE_W-1:0] patCode;
    logic [CODE_W-1:0] laneOut;

    assign chIdx    = CH_W'(lane * SLOTS) + CH_W'(strobes.slot);
    assign convCode = ({1'b0, chIdx} < USED_LIM) ? frameReg[chIdx] : '0;
    assign patCode  = CODE_W'(chIdx) ^ PATTERN_KEY;
    assign laneOut  = !strobes.active ? '0 : (modeReg ? patCode : convCode);

    assign laneData[lane*CODE_W +: CODE_W] = laneOut;
    assign laneValid[lane]                 = strobes.active;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |-> (laneData == '0 && laneValid == '0)); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && !strobes.load) |=> $stable(modeReg)); // R7
  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid == '0 || laneValid == '1)); // R3
endmodule

// File: rtl/frame_lane_serializer.sv
module frame_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int unsigned       USED_CH     = 250,
  parameter logic [CODE_W-1:0] PATTERN_KEY = 8'hA5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameValid,
  output logic                       frameReady,
  input  logic                       testMode,
  input  logic [CHANNELS*CODE_W-1:0] frameData,
  output logic [LANES*CODE_W-1:0]    laneData,
  output logic [LANES-1:0]           laneValid,
  output logic                       frameStart
);
  seqStrobes_t strobes;

  lane_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .frameReady (frameReady),
    .frameStart (frameStart),
    .strobes    (strobes)
  );

  lane_datapath #(
    .USED_CH     (USED_CH),
    .PATTERN_KEY (PATTERN_KEY)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .testModeIn (testMode),
    .frameData  (frameData),
    .laneData   (laneData),
    .laneValid  (laneValid)
  );

  AST_START_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (laneValid == '1 && !frameReady)); // R3
endmodule

// File: tb/frame_lane_serializer_tb.sv
module frame_lane_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8, NS = 32, NC = 256, USED = 250;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameValid = 1'b0;
  logic            testMode = 1'b0;
  logic [NC*8-1:0] frameData = '0;
  logic            frameReady;
  logic [NL*8-1:0] laneData;
  logic [NL-1:0]   laneValid;
  logic            frameStart;

  frame_lane_serializer u_dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameReady(frameReady),
    .testMode(testMode), .frameData(frameData), .laneData(laneData),
    .laneValid(laneValid), .frameStart(frameStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string curTag = "";

  // reference model state
  byte unsigned mdlData [NC];
  bit  mdlMode = 1'b0;
  bit  mdlBusy = 1'b0;
  int  mdlSlot = 0;

  function automatic bit expReady();
    return !mdlBusy || (mdlSlot == NS - 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mdlBusy = 1'b0;
      mdlSlot = 0;
    end else begin
      bit acc;
      acc = frameValid && expReady();
      if (mdlBusy) begin
        if (mdlSlot == NS - 1) mdlBusy = 1'b0;
        else mdlSlot++;
      end
      if (acc) begin
        for (int c = 0; c < NC; c++) mdlData[c] = frameData[c*8 +: 8];
        mdlMode = testMode;
        mdlBusy = 1'b1;
        mdlSlot = 0;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string t;
      t = (curTag != "") ? curTag : "R2";
      check(t, "frameReady", int'(frameReady), int'(expReady()));
      t = (curTag != "") ? curTag : (mdlBusy ? "R3" : "R9");
      check(t, "frameStart", int'(frameStart), int'(mdlBusy && mdlSlot == 0));
      check(t, "laneValid", int'(laneValid), mdlBusy ? 8'hFF : 0);
      for (int k = 0; k < NL; k++) begin
        int ch, exp;
        ch = k * NS + mdlSlot;
        if (!mdlBusy) begin exp = 0; t = "R9"; end
        else if (mdlMode) begin exp = ((k << 5) | mdlSlot) ^ 8'hA5; t = "R6"; end
        else if (ch >= USED) begin exp = 0; t = "R5"; end
        else begin exp = mdlData[ch]; t = "R4"; end
        if (curTag != "") t = curTag;
        check(t, $sformatf("lane%0d", k), int'(laneData[k*8 +: 8]), exp);
      end
    end
  end

  task automatic fillFrame(int seed);
    for (int c = 0; c < NC; c++)
      frameData[c*8 +: 8] = 8'((c * 37 + seed * 11 + 3) ^ (seed << 4));
  endtask

  task automatic offerFrame(int seed, bit mode);
    bit r;
    fillFrame(seed);
    testMode = mode;
    frameValid = 1'b1;
    do begin
      r = frameReady;
      @(negedge clk);
    end while (!r);
    frameValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    curTag = "";
    // R4 R5: normal frame with mixed data, spare channels driven nonzero
    offerFrame(1, 1'b0);
    idle(40);
    // R5: all ones input, spare channels must still read zero
    frameData = '1; testMode = 1'b0; frameValid = 1'b1;
    begin bit r; do begin r = frameReady; @(negedge clk); end while (!r); end
    frameValid = 1'b0;
    idle(36);
    // R6: link-test pattern
    offerFrame(2, 1'b1);
    idle(35);
    // R7: scramble inputs during a frame
    curTag = "R7";
    offerFrame(3, 1'b0);
    idle(3);
    fillFrame(9); testMode = 1'b1;
    idle(10);
    frameData = '0; testMode = 1'b0;
    idle(25);
    // R8: back-to-back frames, second offered immediately
    curTag = "R8";
    offerFrame(4, 1'b0);
    offerFrame(5, 1'b1);
    offerFrame(6, 1'b0);
    curTag = "";
    idle(40);
    // R2: offer held while ready is low does not restart the frame
    offerFrame(7, 1'b1);
    fillFrame(8); frameValid = 1'b1;
    idle(5);
    frameValid = 1'b0;
    idle(40);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule